// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block is the column-access engine on the device side of a synchronous DRAM. It accepts a decoded read or write command together with a column address on a rising clock edge. It then performs a burst of accesses to consecutive columns of a small register array that stands in for the open row. Write data is taken from the data input starting on the command edge itself. Read data is driven onto the data output a selectable number of cycles later, with an output enable that releases the bus whenever no read word is presented.

Burst length and read latency are static mode inputs. A command of the same kind that arrives while a burst is running cuts that burst short at once and starts a new one. Reads take over the output after their own latency, with no idle cycle between the old words and the new ones. Writes take over on the command edge. A command of the other kind also ends the running burst. Reads and writes may be issued on every clock edge.

Top module: `colBurstSeq`

## Requirements
- R1: While reset is held and after its release with no command, `dqOe` and `dataValid` are 0 and `dqOut` is 0.
- R2: A write command stores `dqIn` at `colAddr` on the command edge; on each of the next BL-1 edges, provided no command arrives, `dqIn` is stored at the next burst column.
- R3: `burstSel` selects BL: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. Beat i of a burst addresses the column whose bits above the low log2(BL) bits equal those of the start column. Its low log2(BL) bits are (start + i) mod BL, so the burst wraps inside its BL-aligned block.
- R4: `casSel` 0 selects latency 2 and 1 selects latency 3. For a read command on edge k, word i of the burst is presented from edge k+CL-1+i until edge k+CL+i, so a controller samples it on edge k+CL+i. The BL words follow one per cycle.
- R5: A read command during a read burst ends the old burst. The new first word appears CL cycles after the new command, directly after the old words already fetched, with no idle cycle. Reads on consecutive edges each deliver one word.
- R6: A write command during a write burst ends the old burst immediately. The new burst stores its first word on its own command edge, and the old burst stores nothing further.
- R7: `dqOe` and `dataValid` are 1 exactly in the cycles in which a read word is presented. In every other cycle `dqOut` is 0, and the output is never enabled while a write burst beat is stored.
- R8: A write command ends a read burst and withdraws every read word not yet presented; from the write command edge onward `dqOe` is 0.
- R9: A read command ends a write burst; `dqIn` is not stored on that edge or any later edge of the cut burst.
- R10: When `cmdRead` and `cmdWrite` are both 1 on an edge, the read is performed and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdRead | input | 1 | Read command, sampled on the edge |
| cmdWrite | input | 1 | Write command, sampled on the edge |
| colAddr | input | COL_BITS (6) | Start column of the burst |
| burstSel | input | 2 | Burst length code (static) |
| casSel | input | 1 | Read latency code (static) |
| dqIn | input | DATA_W | Write data from the bus |
| dqOut | output | DATA_W | Read data to the bus, 0 when not driven |
| dqOe | output | 1 | Bus drive enable for read data |
| dataValid | output | 1 | Marks each cycle with a read word presented |

## Verification
The bench builds the block with its default 16-bit words and 64-column array. This is small enough that eight 8-beat write bursts fill every column with a known value. Block wrap at both aligned and unaligned start columns then falls within a few short bursts. Both latency settings and all four burst lengths are chosen at run time through the mode inputs. One build therefore reaches every latency against every interrupt pattern, including back-to-back reads and writes on consecutive edges.

// File: rtl/colBurstPkg.sv
package colBurstPkg;

  // Column address width of the stand-in cell array
  parameter int COL_BITS = 6;
  // Largest burst is 2**MAX_BL_LOG beats
  parameter int MAX_BL_LOG = 3;
  // Smallest read latency; casSel adds 0 or 1
  parameter int CL_MIN = 2;
  // Read pipeline depth covers the largest latency
  localparam int STAGES = CL_MIN + 1;

  typedef struct packed {
    logic                rdEn;   // fetch one word into the read pipeline
    logic                wrEn;   // store dqIn at addr
    logic                flush;  // drop pending read words
    logic [COL_BITS-1:0] addr;   // column of this beat
  } colStrobe_t;

  // Mask of the low address bits that wrap inside a burst
  function automatic logic [COL_BITS-1:0] burstMask(input logic [1:0] sel);
    logic [COL_BITS-1:0] m;
    m = '0;
    for (int b = 0; b < MAX_BL_LOG; b++) begin
      if (b < int'(sel)) m[b] = 1'b1;
    end
    return m;
  endfunction

  // Column of beat number 'beat' for a burst starting at 'base'
  function automatic logic [COL_BITS-1:0] burstCol(input logic [COL_BITS-1:0] base,
                                                   input logic [COL_BITS-1:0] beat,
                                                   input logic [1:0]          sel);
    logic [COL_BITS-1:0] m;
    m = burstMask(sel);
    return (base & ~m) | ((base + beat) & m);
  endfunction

endpackage

// File: rtl/colBurstCtrl.sv
module colBurstCtrl
  import colBurstPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdRead,
  input  logic                cmdWrite,
  input  logic [COL_BITS-1:0] colAddr,
  input  logic [1:0]          burstSel,
  output colStrobe_t          strb
);

  localparam int CNT_W = MAX_BL_LOG;

  logic                active;
  logic                isRead;
  logic [COL_BITS-1:0] baseCol;
  logic [CNT_W-1:0]    beatCnt;
  logic [COL_BITS-1:0] fullMask;
  logic [CNT_W-1:0]    lastBeat;
  logic                newCmd;

  assign fullMask = burstMask(burstSel);
  assign lastBeat = fullMask[CNT_W-1:0];
  assign newCmd   = cmdRead | cmdWrite;

  // Beat 0 comes straight from the command; later beats from the counter
  always_comb begin
    strb = '0;
    if (cmdRead) begin
      strb.rdEn = 1'b1;
      strb.addr = colAddr;
    end else if (cmdWrite) begin
      strb.wrEn  = 1'b1;
      strb.flush = 1'b1;
      strb.addr  = colAddr;
    end else if (active) begin
      strb.rdEn = isRead;
      strb.wrEn = ~isRead;
      strb.addr = burstCol(baseCol, COL_BITS'(beatCnt), burstSel);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      isRead  <= 1'b0;
      baseCol <= '0;
      beatCnt <= '0;
    end else if (newCmd) begin
      active  <= (burstSel != 2'd0);
      isRead  <= cmdRead;
      baseCol <= colAddr;
      beatCnt <= CNT_W'(1);
    end else if (active) begin
      if (beatCnt == lastBeat) active <= 1'b0;
      beatCnt <= beatCnt + CNT_W'(1);
    end
  end

  AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (beatCnt != '0 && beatCnt <= lastBeat)); // R3

  AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (active && beatCnt == lastBeat && !cmdRead && !cmdWrite) |=> !active); // R2

  AST_CMD_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdRead || cmdWrite) && burstSel != 2'd0) |=> (active && beatCnt == CNT_W'(1))); // R5

  AST_READ_BEATS_STAY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && burstSel != 2'd0) |=> isRead); // R10

endmodule

// File: rtl/colBurstData.sv
module colBurstData
  import colBurstPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  colStrobe_t        strb,
  input  logic              casSel,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  localparam int DEPTH = 1 << COL_BITS;
  localparam int IDX_W = $clog2(STAGES);

  logic [DATA_W-1:0] cellArr [DEPTH];
  logic [STAGES-1:0] stV;
  logic [DATA_W-1:0] stD [STAGES];
  logic [IDX_W-1:0]  selIdx;

  // Stand-in cell array: write on the edge, read combinationally
  always_ff @(posedge clk) begin
    if (strb.wrEn) cellArr[strb.addr] <= dqIn;
  end

  // Read pipeline: stage 0 takes the fetched word, later stages shift
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stV <= '0;
      for (int s = 0; s < STAGES; s++) stD[s] <= '0;
    end else if (strb.flush) begin
      stV <= '0;
    end else begin
      stV[0] <= strb.rdEn;
      stD[0] <= cellArr[strb.addr];
      for (int s = 1; s < STAGES; s++) begin
        stV[s] <= stV[s-1];
        stD[s] <= stD[s-1];
      end
    end
  end

  // Latency picks which stage feeds the bus
  assign selIdx = IDX_W'(CL_MIN - 1) + IDX_W'(casSel);

  always_comb begin
    dqOe  = stV[selIdx];
    dqOut = dqOe ? stD[selIdx] : '0;
  end

  AST_FLUSH_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> !dqOe); // R8

  AST_CL2_FIRST_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (!casSel && $past(strb.rdEn) && !strb.flush) |=> dqOe); // R4

  AST_CL3_FIRST_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (casSel && $past(strb.rdEn, 2) && !$past(strb.flush) && !strb.flush) |=> dqOe); // R4

  AST_NO_DRIVE_ON_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.flush) |-> !dqOe); // R7

  AST_ONE_ACCESS_KIND: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdEn && strb.wrEn)); // R10

endmodule

// File: rtl/colBurstSeq.sv
module colBurstSeq
  import colBurstPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdRead,
  input  logic                cmdWrite,
  input  logic [COL_BITS-1:0] colAddr,
  input  logic [1:0]          burstSel,
  input  logic                casSel,
  input  logic [DATA_W-1:0]   dqIn,
  output logic [DATA_W-1:0]   dqOut,
  output logic                dqOe,
  output logic                dataValid
);

  colStrobe_t strb;

  colBurstCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdRead  (cmdRead),
    .cmdWrite (cmdWrite),
    .colAddr  (colAddr),
    .burstSel (burstSel),
    .strb     (strb)
  );

  colBurstData #(.DATA_W(DATA_W)) i_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .casSel (casSel),
    .dqIn   (dqIn),
    .dqOut  (dqOut),
    .dqOe   (dqOe)
  );

  assign dataValid = dqOe;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !dqOe); // R1

endmodule

// File: tb/test_colBurstSeq.sv
module test_colBurstSeq;
  import colBurstPkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;
  localparam int NCOL       = 1 << COL_BITS;
  localparam int SLOTS      = 80;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                cmdRead = 1'b0;
  logic                cmdWrite = 1'b0;
  logic [COL_BITS-1:0] colAddr = '0;
  logic [1:0]          burstSel = 2'd0;
  logic                casSel = 1'b0;
  logic [DW-1:0]       dqIn = '0;
  logic [DW-1:0]       dqOut;
  logic                dqOe;
  logic                dataValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0]       refMem [NCOL];
  bit                  sRd   [SLOTS];
  bit                  sWr   [SLOTS];
  logic [COL_BITS-1:0] sAddr [SLOTS];
  logic [DW-1:0]       sData [SLOTS];
  bit                  eV    [SLOTS];
  logic [DW-1:0]       eD    [SLOTS];

  always #(CLK_PERIOD/2) clk = ~clk;

  colBurstSeq #(.DATA_W(DW)) i_colBurstSeq (
    .clk       (clk),
    .rstN      (rstN),
    .cmdRead   (cmdRead),
    .cmdWrite  (cmdWrite),
    .colAddr   (colAddr),
    .burstSel  (burstSel),
    .casSel    (casSel),
    .dqIn      (dqIn),
    .dqOut     (dqOut),
    .dqOe      (dqOe),
    .dataValid (dataValid)
  );

  // Column of beat i: upper bits from start, low bits count mod length
  function automatic logic [COL_BITS-1:0] colAt(input int base, input int i, input int bl);
    int blockStart;
    blockStart = base - (base % bl);
    return COL_BITS'(blockStart + ((base % bl) + i) % bl);
  endfunction

  function automatic int curBl();
    return 1 << burstSel;
  endfunction

  function automatic int curCl();
    return casSel ? 3 : 2;
  endfunction

  task automatic checkBus(input int j, input string req);
    logic [DW-1:0] expD;
    expD = eV[j] ? eD[j] : '0;
    checks++;
    if (dqOe !== eV[j] || dataValid !== eV[j] || dqOut !== expD) begin
      fails++;
      $display("FAIL %s cycle %0d: oe=%b valid=%b data=%h, expected oe=%b valid=%b data=%h",
               req, j, dqOe, dataValid, dqOut, eV[j], eV[j], expD);
    end
  endtask

  task automatic clearSched();
    for (int j = 0; j < SLOTS; j++) begin
      sRd[j] = 1'b0; sWr[j] = 1'b0; sAddr[j] = '0; sData[j] = '0;
      eV[j] = 1'b0;  eD[j] = '0;
    end
  endtask

  // Write burst at slot j, of which only nBeats beats take effect
  task automatic schedWrite(input int j, input int base, input logic [DW-1:0] seed, input int nBeats);
    sWr[j]   = 1'b1;
    sAddr[j] = COL_BITS'(base);
    for (int i = 0; i < nBeats; i++) begin
      sData[j+i] = seed + DW'(i);
      refMem[colAt(base, i, curBl())] = seed + DW'(i);
    end
  endtask

  // Read burst at slot j, of which nBeats words reach the bus
  task automatic schedRead(input int j, input int base, input int nBeats);
    sRd[j]   = 1'b1;
    sAddr[j] = COL_BITS'(base);
    for (int i = 0; i < nBeats; i++) begin
      eV[j + curCl() - 1 + i] = 1'b1;
      eD[j + curCl() - 1 + i] = refMem[colAt(base, i, curBl())];
    end
  endtask

  // Slot j drives the inputs for edge j; bus is checked right after it
  task automatic runSched(input int n, input string req);
    for (int j = 0; j < n; j++) begin
      cmdRead  = sRd[j];
      cmdWrite = sWr[j];
      colAddr  = sAddr[j];
      dqIn     = sData[j];
      @(negedge clk);
      checkBus(j, req);
    end
    cmdRead  = 1'b0;
    cmdWrite = 1'b0;
    dqIn     = '0;
  endtask

  task automatic readBack(input int base, input string req);
    clearSched();
    schedRead(0, base, curBl());
    runSched(curCl() + curBl() + 1, req);
  endtask

  task automatic testReset();
    eV[0] = 1'b0; eD[0] = '0;
    repeat (3) @(negedge clk);
    checkBus(0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    checkBus(0, "R1");
    @(negedge clk);
    checkBus(0, "R1");
  endtask

  task automatic testFill();
    burstSel = 2'd3;
    casSel   = 1'b0;
    clearSched();
    for (int b = 0; b < NCOL / 8; b++) schedWrite(b * 8, b * 8, DW'(16'h3000 + b * 16'h0111), 8);
    runSched(NCOL, "R2");
    for (int b = 0; b < NCOL / 8; b++) readBack(b * 8, "R2");
  endtask

  task automatic testReadBasic(input bit cl3);
    casSel = cl3;
    for (int sel = 0; sel < 4; sel++) begin
      burstSel = 2'(sel);
      readBack(5 + sel * 9, "R4");
      readBack(sel * 8, "R4");
    end
  endtask

  task automatic testWrap();
    burstSel = 2'd3;
    casSel   = 1'b0;
    clearSched();
    schedWrite(0, 13, 16'h7700, 8);
    runSched(10, "R3");
    readBack(13, "R3");
    burstSel = 2'd2;
    readBack(6, "R3");
    burstSel = 2'd1;
    readBack(31, "R3");
  endtask

  task automatic testReadInterrupt(input bit cl3);
    casSel   = cl3;
    burstSel = 2'd2;
    clearSched();
    schedRead(0, 20, 1);
    schedRead(1, 33, 4);
    runSched(curCl() + 7, "R5");
    clearSched();
    schedRead(0, 2, 1);
    schedRead(1, 45, 1);
    schedRead(2, 58, 1);
    schedRead(3, 11, 4);
    runSched(curCl() + 9, "R5");
  endtask

  task automatic testWriteInterrupt();
    burstSel = 2'd2;
    casSel   = 1'b0;
    clearSched();
    schedWrite(0, 40, 16'hA100, 1);
    schedWrite(1, 50, 16'hB200, 4);
    runSched(8, "R6");
    readBack(40, "R6");
    readBack(50, "R6");
    clearSched();
    schedWrite(0, 24, 16'hC300, 1);
    schedWrite(1, 29, 16'hC400, 1);
    schedWrite(2, 35, 16'hC500, 4);
    runSched(8, "R6");
    readBack(24, "R6");
    readBack(28, "R6");
    readBack(35, "R6");
  endtask

  task automatic testWriteCutsRead();
    burstSel = 2'd2;
    casSel   = 1'b0;
    clearSched();
    schedRead(0, 8, 1);
    schedWrite(2, 60, 16'hD400, 4);
    runSched(8, "R8");
    casSel = 1'b1;
    clearSched();
    schedRead(0, 8, 0);
    schedWrite(1, 56, 16'hD500, 4);
    runSched(8, "R8");
    readBack(60, "R8");
    readBack(56, "R8");
  endtask

  task automatic testReadCutsWrite();
    burstSel = 2'd2;
    casSel   = 1'b0;
    clearSched();
    schedWrite(0, 32, 16'hE500, 2);
    schedRead(2, 16, 4);
    for (int j = 2; j < 8; j++) sData[j] = 16'hDEAD;
    runSched(9, "R9");
    readBack(32, "R9");
  endtask

  task automatic testBothCmd();
    burstSel = 2'd1;
    casSel   = 1'b0;
    clearSched();
    schedRead(0, 44, 2);
    sWr[0]   = 1'b1;
    sData[0] = 16'hBEEF;
    sData[1] = 16'hBEEF;
    runSched(5, "R10");
    readBack(44, "R10");
  endtask

  initial begin
    for (int c = 0; c < NCOL; c++) refMem[c] = '0;
    clearSched();
    testReset();
    testFill();
    testReadBasic(1'b0);
    testReadBasic(1'b1);
    testWrap();
    testReadInterrupt(1'b0);
    testReadInterrupt(1'b1);
    testWriteInterrupt();
    testWriteCutsRead();
    testReadCutsWrite();
    testBothCmd();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual still running, expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule